// File: doc/BRIEF.md
# I2C 10-bit Slave Address Sequencer

This block sits above a bit-level I2C slave receiver and walks a slave through the two-byte 10-bit address phase. The receiver gives it byte-complete strobes and START/STOP strobes. The block decides which received byte is the 10-bit header byte, which one is the low address byte, and when the slave has been fully addressed. The header byte is the first byte after a START whose upper five bits are `11110`; its next two bits carry address bits 9:8, and its last bit is the read/write bit.

A single 8-bit compare register is written by software. It is first loaded with the header value, so that the header byte can be matched. After the header byte matches, the block sets an update-address flag and holds SCL low until software writes the low address byte into the register. After the low byte matches, the block holds SCL low again until software writes the header value back.

On a later repeated START, a header byte that carries a read request is matched on its own. This is allowed only if the full 10-bit address has matched since the last STOP. The slave then moves to transmit.

Top module: `tenbit_addr_seq`

## Requirements
- R1: The first byte after a START is taken as a header only if bits 7:3 equal `11110` and bits 2:1 equal bits 2:1 of the compare register. Any other first byte returns the block to idle (state 0) with no ACK.
- R2: A header byte with bit 0 = 0 (write) moves the block on to wait for the low address byte. A header byte with bit 0 = 1 (read) is refused, leaving the block idle with no ACK, unless R7 allows it.
- R3: A header write match gives a one-cycle ACK pulse. It sets buffer-full, the interrupt flag and update-address, asserts the SCL hold, and puts the block in state 1 (header matched). All of these appear one clock after the byte strobe.
- R4: A software write to the compare register clears update-address and releases the SCL hold on the next clock, provided no address-setting byte event falls on the same clock.
- R5: In state 1, the next byte is compared in full (all 8 bits) against the compare register. On a match, the block gives an ACK pulse, sets update-address, buffer-full, the interrupt flag and the SCL hold, enters state 2 (addressed for write), and records that the full address has matched.
- R6: In state 1, a byte that does not equal the compare register returns the block to state 0 with no ACK and leaves all flags unchanged. Bytes received in state 2 or state 3 are data and change nothing.
- R7: After a START, a header byte with bit 0 = 1 is accepted only if the full address has matched since the last STOP. The block then enters state 3 (addressed for read), asserts the transmit output, gives an ACK, and sets buffer-full and the interrupt flag. Update-address stays clear and SCL is not held.
- R8: A STOP clears the record of a full address match, so a later header-only read is refused.
- R9: Reset leaves every output low and the state at 0. A STOP returns the block to state 0 with transmit clear on the next clock, with priority over START and byte strobes on the same clock.
- R10: A buffer-read pulse clears buffer-full and an interrupt-clear pulse clears the interrupt flag. A setting event on the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START strobe from the receiver |
| stop_i | input | 1 | STOP strobe from the receiver |
| byte_valid_i | input | 1 | Byte-complete strobe |
| byte_i | input | 8 | Received byte, valid with byte_valid_i |
| addr_wr_i | input | 1 | Software write to the compare register |
| addr_wdata_i | input | 8 | Value written to the compare register |
| buf_read_i | input | 1 | Software read of the receive buffer |
| irq_clr_i | input | 1 | Software clear of the interrupt flag |
| ack_o | output | 1 | One-cycle pulse: address byte acknowledged |
| update_addr_o | output | 1 | Software must reload the compare register |
| buf_full_o | output | 1 | Buffer-full flag |
| irq_o | output | 1 | Interrupt flag |
| scl_hold_o | output | 1 | Hold SCL low |
| xmit_o | output | 1 | Slave is addressed for transmit |
| state_o | output | 2 | 0 idle, 1 header matched, 2 addressed for write, 3 addressed for read |

## Verification
The assertions take for granted that the receiver raises at most one of START and STOP per clock. They also assume that a software write to the compare register does not share a clock with a byte strobe while the release is being checked. The R4 property therefore excludes the byte-strobe case rather than requiring it away. The directed part of the stimulus follows a well-behaved driver that reloads the register between address bytes. The pseudo-random part mixes strobes freely, including clashes with clears, and relies on the bench's reference model for those cycles.

// File: rtl/tba_pkg.sv
package tba_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_WR   = 2'd2,
    ST_RD   = 2'd3
  } seq_st_e;

  localparam int unsigned FLAG_UADD = 0;
  localparam int unsigned FLAG_BF   = 1;
  localparam int unsigned FLAG_IRQ  = 2;
  localparam int unsigned FLAG_N    = 3;
endpackage

// File: rtl/tba_addr_cmp.sv
module tba_addr_cmp #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned TAG_W   = 5,
  parameter logic [TAG_W-1:0] TAG = 5'b11110,
  parameter logic [BYTE_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              hdr_ok_o,
  output logic              rw_o,
  output logic              low_ok_o
);
  localparam int unsigned UP_MSB = BYTE_W - TAG_W - 1;

  logic [BYTE_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= RST_VAL;
    else if (wr_i) addr_q <= wdata_i;
  end

  // header: fixed tag, then upper address bits against the register copy
  assign hdr_ok_o = (byte_i[BYTE_W-1 -: TAG_W] == TAG) &&
                    (byte_i[UP_MSB:1] == addr_q[UP_MSB:1]);
  assign rw_o     = byte_i[0];
  assign low_ok_o = (byte_i == addr_q);
endmodule

// File: rtl/tba_seq.sv
module tba_seq
  import tba_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_valid_i,
  input  logic       hdr_ok_i,
  input  logic       rw_i,
  input  logic       low_ok_i,
  output logic       set_uadd_o,
  output logic       set_bf_o,
  output logic       ack_o,
  output logic       xmit_o,
  output seq_st_e    state_o
);
  seq_st_e st_q, st_d;
  logic expect_q, expect_d;
  logic full_q, full_d;
  logic xmit_q, xmit_d;
  logic ack_q;

  logic hdr_wr_hit, hdr_rd_hit, low_hit, miss, quiet;

  assign quiet      = !stop_i && !start_i;
  assign hdr_wr_hit = quiet && byte_valid_i && expect_q && hdr_ok_i && !rw_i;
  assign hdr_rd_hit = quiet && byte_valid_i && expect_q && hdr_ok_i && rw_i && full_q;
  assign low_hit    = quiet && byte_valid_i && (st_q == ST_HDR) && low_ok_i;
  assign miss       = quiet && byte_valid_i &&
                      ((expect_q && !hdr_wr_hit && !hdr_rd_hit) ||
                       ((st_q == ST_HDR) && !low_ok_i));

  always_comb begin
    st_d     = st_q;
    expect_d = expect_q;
    full_d   = full_q;
    xmit_d   = xmit_q;
    if (stop_i) begin
      st_d = ST_IDLE; expect_d = 1'b0; full_d = 1'b0; xmit_d = 1'b0;
    end else if (start_i) begin
      st_d = ST_IDLE; expect_d = 1'b1; xmit_d = 1'b0;
    end else if (hdr_wr_hit) begin
      st_d = ST_HDR; expect_d = 1'b0;
    end else if (hdr_rd_hit) begin
      st_d = ST_RD; expect_d = 1'b0; xmit_d = 1'b1;
    end else if (low_hit) begin
      st_d = ST_WR; full_d = 1'b1;
    end else if (miss) begin
      st_d = ST_IDLE; expect_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      expect_q <= 1'b0;
      full_q   <= 1'b0;
      xmit_q   <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      expect_q <= expect_d;
      full_q   <= full_d;
      xmit_q   <= xmit_d;
      ack_q    <= hdr_wr_hit || hdr_rd_hit || low_hit;
    end
  end

  assign set_uadd_o = hdr_wr_hit || low_hit;
  assign set_bf_o   = hdr_wr_hit || hdr_rd_hit || low_hit;
  assign ack_o      = ack_q;
  assign xmit_o     = xmit_q;
  assign state_o    = st_q;
endmodule

// File: rtl/tba_flags.sv
module tba_flags
  import tba_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_N-1:0] set_i,
  input  logic [FLAG_N-1:0] clr_i,
  output logic [FLAG_N-1:0] flag_o
);
  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (set_i[g]) f_q <= 1'b1;   // set wins
      else if (clr_i[g]) f_q <= 1'b0;
    end
    assign flag_o[g] = f_q;
  end
endmodule

// File: rtl/tenbit_addr_seq.sv
module tenbit_addr_seq
  import tba_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned TAG_W  = 5,
  parameter logic [TAG_W-1:0] TAG = 5'b11110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              addr_wr_i,
  input  logic [BYTE_W-1:0] addr_wdata_i,
  input  logic              buf_read_i,
  input  logic              irq_clr_i,
  output logic              ack_o,
  output logic              update_addr_o,
  output logic              buf_full_o,
  output logic              irq_o,
  output logic              scl_hold_o,
  output logic              xmit_o,
  output logic [1:0]        state_o
);
  logic hdr_ok, rw, low_ok, set_uadd, set_bf;
  logic [FLAG_N-1:0] fset, fclr, flags;
  seq_st_e st;

  tba_addr_cmp #(.BYTE_W(BYTE_W), .TAG_W(TAG_W), .TAG(TAG), .RST_VAL('0)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(addr_wr_i), .wdata_i(addr_wdata_i),
    .byte_i(byte_i), .hdr_ok_o(hdr_ok), .rw_o(rw), .low_ok_o(low_ok)
  );

  tba_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .byte_valid_i(byte_valid_i), .hdr_ok_i(hdr_ok), .rw_i(rw), .low_ok_i(low_ok),
    .set_uadd_o(set_uadd), .set_bf_o(set_bf), .ack_o(ack_o), .xmit_o(xmit_o),
    .state_o(st)
  );

  always_comb begin
    fset = '0;
    fclr = '0;
    fset[FLAG_UADD] = set_uadd;
    fset[FLAG_BF]   = set_bf;
    fset[FLAG_IRQ]  = set_bf;
    fclr[FLAG_UADD] = addr_wr_i;
    fclr[FLAG_BF]   = buf_read_i;
    fclr[FLAG_IRQ]  = irq_clr_i;
  end

  tba_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(fset), .clr_i(fclr), .flag_o(flags)
  );

  assign update_addr_o = flags[FLAG_UADD];
  assign scl_hold_o    = flags[FLAG_UADD];  // stretch until reload
  assign buf_full_o    = flags[FLAG_BF];
  assign irq_o         = flags[FLAG_IRQ];
  assign state_o       = st;
endmodule

// File: rtl/tenbit_addr_seq_chk.sv
module tenbit_addr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       byte_valid_i,
  input logic       addr_wr_i,
  input logic       ack_o,
  input logic       update_addr_o,
  input logic       buf_full_o,
  input logic       irq_o,
  input logic       scl_hold_o,
  input logic       xmit_o,
  input logic [1:0] state_o
);
  AST_ACK_SETS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (buf_full_o && irq_o)); // R3
  AST_RELOAD_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_wr_i && !byte_valid_i) |=> !scl_hold_o); // R4
  AST_WR_VIA_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'd2 && state_o != 2'd1) |=> state_o != 2'd2); // R5
  AST_READ_NO_UADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xmit_o) |-> !$rose(update_addr_o)); // R7
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_o == 2'd0 && !xmit_o && !ack_o)); // R9
  AST_XMIT_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xmit_o |-> state_o == 2'd3); // R7
endmodule

bind tenbit_addr_seq tenbit_addr_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .byte_valid_i(byte_valid_i), .addr_wr_i(addr_wr_i), .ack_o(ack_o),
  .update_addr_o(update_addr_o), .buf_full_o(buf_full_o), .irq_o(irq_o),
  .scl_hold_o(scl_hold_o), .xmit_o(xmit_o), .state_o(state_o)
);

// File: tb/tenbit_addr_seq_test.sv
module tenbit_addr_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, stop, bval, awr, bread, iclr;
  logic [7:0] bdat, awdata;
  logic ack, uadd, bf, irq, hold, xmit;
  logic [1:0] st;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tenbit_addr_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_valid_i(bval), .byte_i(bdat), .addr_wr_i(awr), .addr_wdata_i(awdata),
    .buf_read_i(bread), .irq_clr_i(iclr), .ack_o(ack), .update_addr_o(uadd),
    .buf_full_o(bf), .irq_o(irq), .scl_hold_o(hold), .xmit_o(xmit), .state_o(st)
  );

  // behavioural reference model
  int m_st, m_addr;
  bit m_exp, m_full, m_xmit, m_ack, m_uadd, m_bf, m_irq;

  always @(posedge clk) begin
    bit is_hdr, hw, hr, lo, setb;
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_exp = 0; m_full = 0; m_xmit = 0;
      m_ack = 0; m_uadd = 0; m_bf = 0; m_irq = 0;
    end else begin
      is_hdr = ((int'(bdat) >> 3) == 30) && (((int'(bdat) >> 1) & 3) == ((m_addr >> 1) & 3));
      hw = 0; hr = 0; lo = 0;
      if (stop) begin
        m_st = 0; m_exp = 0; m_full = 0; m_xmit = 0;
      end else if (start) begin
        m_st = 0; m_exp = 1; m_xmit = 0;
      end else if (bval && m_exp) begin
        m_exp = 0;
        if (is_hdr && bdat[0] == 1'b0) begin hw = 1; m_st = 1; end
        else if (is_hdr && m_full) begin hr = 1; m_st = 3; m_xmit = 1; end
        else m_st = 0;
      end else if (bval && m_st == 1) begin
        if (int'(bdat) == m_addr) begin lo = 1; m_st = 2; m_full = 1; end
        else m_st = 0;
      end
      setb = hw || hr || lo;
      m_ack = setb;
      if (hw || lo) m_uadd = 1; else if (awr) m_uadd = 0;
      if (setb) m_bf = 1; else if (bread) m_bf = 0;
      if (setb) m_irq = 1; else if (iclr) m_irq = 0;
      if (awr) m_addr = int'(awdata);
    end
  end

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  always @(negedge clk) if (cmp_en && !done) begin
    checks++;
    if (ack  !== m_ack)  fail_line("R3", "ack", ack, m_ack);
    if (uadd !== m_uadd) fail_line("R4", "update_addr", uadd, m_uadd);
    if (hold !== m_uadd) fail_line("R4", "scl_hold", hold, m_uadd);
    if (bf   !== m_bf)   fail_line("R10", "buf_full", bf, m_bf);
    if (irq  !== m_irq)  fail_line("R10", "irq", irq, m_irq);
    if (xmit !== m_xmit) fail_line("R7", "xmit", xmit, m_xmit);
    if (int'(st) != m_st) fail_line("R6", "state", st, m_st);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) fail_line(req, what, act, exp);
  endtask

  task automatic clr_in();
    start = 0; stop = 0; bval = 0; awr = 0; bread = 0; iclr = 0;
    bdat = 8'h00; awdata = 8'h00;
  endtask

  task automatic step(); @(negedge clk); clr_in(); endtask
  task automatic do_start(); start = 1; step(); endtask
  task automatic do_stop();  stop = 1;  step(); endtask
  task automatic do_byte(input logic [7:0] b); bval = 1; bdat = b; step(); endtask
  task automatic do_addr(input logic [7:0] a); awr = 1; awdata = a; step(); endtask
  task automatic do_sw_clr(); bread = 1; iclr = 1; step(); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    clr_in();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset state", int'(st), 0);
    chk("R9", "reset outputs", int'({ack, uadd, bf, irq, hold, xmit}), 0);
    rst_n = 1;
    @(negedge clk);
    cmp_en = 1;

    do_addr(8'hF2);                       // header value, A9:A8 = 01
    do_start(); do_byte(8'h42);
    chk("R1", "7-bit address refused", int'(st), 0);
    chk("R1", "no ack on non-header", int'(ack), 0);
    do_start(); do_byte(8'hF6);
    chk("R1", "wrong A9:A8 refused", int'(st), 0);
    do_start(); do_byte(8'hF3);
    chk("R2", "read header without full match", int'(st), 0);
    chk("R8", "no ack before full match", int'(ack), 0);

    do_start(); do_byte(8'hF2);
    chk("R3", "header write match state", int'(st), 1);
    chk("R3", "ack pulse", int'(ack), 1);
    chk("R3", "hold after header", int'(hold), 1);
    step();
    chk("R3", "ack is one cycle", int'(ack), 0);
    do_addr(8'h5A);
    chk("R4", "reload releases hold", int'(hold), 0);
    do_byte(8'h5B);
    chk("R6", "low byte mismatch", int'(st), 0);
    chk("R6", "no ack on mismatch", int'(ack), 0);

    do_addr(8'hF2); do_sw_clr();
    do_start(); do_byte(8'hF2); do_addr(8'h5A); do_byte(8'h5A);
    chk("R5", "full match state", int'(st), 2);
    chk("R5", "hold after low byte", int'(hold), 1);
    do_addr(8'hF2);
    chk("R4", "header reload releases", int'(uadd), 0);
    do_sw_clr();
    chk("R10", "buf_full cleared", int'(bf), 0);
    chk("R10", "irq cleared", int'(irq), 0);
    do_byte(8'h33);
    chk("R6", "data byte ignored", int'(st), 2);
    chk("R6", "data byte sets no flag", int'(bf), 0);

    do_start(); do_byte(8'hF3);
    chk("R7", "read after repeated start", int'(st), 3);
    chk("R7", "xmit asserted", int'(xmit), 1);
    chk("R7", "update_addr stays clear", int'(uadd), 0);
    do_stop();
    chk("R9", "stop to idle", int'(st), 0);
    chk("R9", "stop clears xmit", int'(xmit), 0);
    do_start(); do_byte(8'hF3);
    chk("R8", "stop forgets full match", int'(st), 0);

    bread = 1; iclr = 1; do_start(); bread = 1; iclr = 1; do_byte(8'hF2);
    chk("R10", "set wins over clear", int'(bf), 1);
    stop = 1; bval = 1; bdat = 8'hF2; step();
    chk("R9", "stop beats byte", int'(st), 0);
    do_addr(8'hF2); do_sw_clr();

    // pseudo-random mix checked against the model each cycle
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[3:0])
        4'd0, 4'd1: start = 1;
        4'd2:       stop = 1;
        4'd3, 4'd4: begin bval = 1; bdat = 8'hF2; end
        4'd5:       begin bval = 1; bdat = 8'hF3; end
        4'd6, 4'd7: begin bval = 1; bdat = 8'h5A; end
        4'd8:       begin bval = 1; bdat = lfsr[15:8]; end
        4'd9:       begin awr = 1; awdata = 8'h5A; end
        4'd10:      begin awr = 1; awdata = 8'hF2; end
        4'd11:      bread = 1;
        4'd12:      iclr = 1;
        default:    ;
      endcase
      if (lfsr[9:8] == 2'b11) bread = 1;
      step();
    end
    step();
    finish_run();
  end
endmodule